// File: doc/BRIEF.md
# External SRAM Wait-State Sequencer

This block times external SRAM cycles on a processor bus. A local configuration register holds one wait-state field for accesses that fall outside every decoded address area and one narrower field for each decoded area, plus a bit that keeps the bus request raised. When an access strobe arrives, the block picks the field for the requested area and clamps a programmed zero to one. It then waits for bus grant and drives chip select for the access wait states, with a ready pulse in the last chip-select cycle. After that it holds the bus for zero, one or two trailing states, chosen by the wait-state count.

The trailing states lengthen data hold and memory release time only. The ready pulse, where read data is taken, does not move with them. The next access is accepted only once the trailing states are over. A field is captured when its access is accepted, so rewriting the register during an access changes only later accesses. The block also reports bus ownership, one cycle behind the grant input.

Top module: `sram_wait_seq`

## Requirements
- R1: After reset the configuration is: default-area field 31, both area fields 7, hold-request bit 0. An access to the default area then runs 32 chip-select cycles and 2 trailing cycles, and busy_o, cs_o, ready_o and bus_req_o are all low while idle.
- R2: The configuration word is laid out as bits [4:0] default-area field, [7:5] area-1 field, [10:8] area-2 field, bit 11 hold-request. area_sel_i code 1 selects the area-1 field, code 2 selects the area-2 field, and codes 0 and 3 select the default-area field.
- R3: For a selected count N, cs_o is high for exactly N+1 consecutive cycles. ready_o pulses once, in the last of those cycles.
- R4: A field programmed to zero is used as N = 1, so chip select lasts two cycles.
- R5: Directly after chip select, hold_o is high, with cs_o low, for 0 cycles when N is 1 to 3, 1 cycle when N is 4 to 7 and 2 cycles when N is 8 or more.
- R6: A strobe that arrives while busy_o is high is ignored. The access in progress is not lengthened and no second access follows it.
- R7: The field is captured when the strobe is accepted. A register write during an access does not change that access.
- R8: With the hold-request bit set, bus_req_o is high at all times. With it clear, bus_req_o is high from the cycle after an accepted strobe until the trailing states end, and low when idle.
- R9: If bus_grant_i is low when a strobe is accepted, the block waits with cs_o low. Chip select starts in the cycle after the first cycle in which grant is high.
- R10: bus_owner_o equals bus_grant_i delayed by one clock.
- R11: A configuration write (cfg_we_i high) takes effect at the next clock edge. The first access accepted after that edge uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 12 | Configuration write data |
| acc_req_i | input | 1 | Access strobe, one cycle |
| area_sel_i | input | 2 | Area code of the access |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| cs_o | output | 1 | Chip select, high during the access wait states |
| ready_o | output | 1 | Access-done pulse, sampled point for read data |
| hold_o | output | 1 | Trailing hold/release phase |
| busy_o | output | 1 | Sequencer not idle |
| bus_req_o | output | 1 | Bus request |
| bus_owner_o | output | 1 | Bus ownership status |

## Verification
A wrong count or a wrong captured field shows up as a cs_o window of the wrong length, or as ready_o out of step with its last cycle. Both appear within the same access, at most about 34 cycles after the strobe. A wrong trailing decision shows as a hold_o run of the wrong length right after ready_o. A sequencer that is stuck or restarts shows as busy_o staying high, or as a second chip-select window, in the first idle cycle after the access. The bench compares every access, including random configurations with zero fields and writes in mid-access, against lengths computed from the area code and the field value.

// File: rtl/sram_ws_pkg.sv
package sram_ws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WGNT = 2'd1,
    ST_ACC  = 2'd2,
    ST_TRL  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sram_ws_cfg.sv
module sram_ws_cfg #(
  parameter int CFG_W = 12,
  parameter logic [CFG_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RST_VAL;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sram_ws_select.sv
module sram_ws_select #(
  parameter int DEF_W      = 5,
  parameter int AREA_W     = 3,
  parameter int NUM_AREAS  = 2,
  parameter int CFG_W      = DEF_W + NUM_AREAS*AREA_W + 1,
  parameter int SEL_W      = 2,
  parameter int CNT_W      = 5,
  parameter int TRAIL1_MIN = 4,
  parameter int TRAIL2_MIN = 8
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [SEL_W-1:0] area_sel_i,
  output logic [CNT_W-1:0] ws_o,
  output logic [1:0]       trail_o
);
  localparam logic [CNT_W-1:0] T1 = CNT_W'(TRAIL1_MIN);
  localparam logic [CNT_W-1:0] T2 = CNT_W'(TRAIL2_MIN);

  logic [CNT_W-1:0] area_ws [NUM_AREAS];
  logic [CNT_W-1:0] raw_ws;

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    assign area_ws[g] = CNT_W'(cfg_i[DEF_W + g*AREA_W +: AREA_W]);
  end

  always_comb begin
    raw_ws = CNT_W'(cfg_i[DEF_W-1:0]);
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (area_sel_i == SEL_W'(i + 1)) raw_ws = area_ws[i];
    end
  end

  // zero is not a legal SRAM setting: run it as one wait state
  assign ws_o = (raw_ws == '0) ? CNT_W'(1) : raw_ws;

  always_comb begin
    if (ws_o >= T2)      trail_o = 2'd2;
    else if (ws_o >= T1) trail_o = 2'd1;
    else                 trail_o = 2'd0;
  end
endmodule

// File: rtl/sram_ws_fsm.sv
module sram_ws_fsm
  import sram_ws_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_req_i,
  input  logic             bus_grant_i,
  input  logic [CNT_W-1:0] ws_i,
  input  logic [1:0]       trail_i,
  output logic             cs_o,
  output logic             ready_o,
  output logic             hold_o,
  output logic             busy_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ws_q;
  logic [1:0]       trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ws_q    <= '0;
      trail_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc_req_i) begin
          ws_q    <= ws_i;
          trail_q <= trail_i;
          if (bus_grant_i) begin
            state_q <= ST_ACC;
            cnt_q   <= ws_i;
          end else begin
            state_q <= ST_WGNT;
          end
        end
        ST_WGNT: if (bus_grant_i) begin
          state_q <= ST_ACC;
          cnt_q   <= ws_q;
        end
        ST_ACC: begin
          if (cnt_q == '0) begin
            if (trail_q != 2'd0) begin
              state_q <= ST_TRL;
              cnt_q   <= CNT_W'(trail_q - 2'd1);
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_TRL: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o    = (state_q == ST_ACC);
  assign ready_o = (state_q == ST_ACC) && (cnt_q == '0);
  assign hold_o  = (state_q == ST_TRL);
  assign busy_o  = (state_q != ST_IDLE);

  // R3: ready closes the chip-select window
  p_ready_ends_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !cs_o);
  // R4: an access never starts with a zero count
  p_ws_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (cnt_q != '0));
  // R5: trailing states follow the ready pulse directly
  p_trail_after_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(ready_o));
  // R7: captured field stays put for the whole access
  p_ws_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o)) |-> $stable(ws_q));
  // R9: chip select only after a seen grant
  p_start_on_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> $past(bus_grant_i));
endmodule

// File: rtl/sram_ws_bus.sv
module sram_ws_bus (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic busy_i,
  input  logic bus_grant_i,
  output logic bus_req_o,
  output logic bus_owner_o
);
  logic owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= 1'b0;
    else         owner_q <= bus_grant_i;
  end

  assign bus_req_o   = hold_req_i | busy_i;
  assign bus_owner_o = owner_q;
endmodule

// File: rtl/sram_wait_seq.sv
module sram_wait_seq #(
  parameter int DEF_W      = 5,
  parameter int AREA_W     = 3,
  parameter int NUM_AREAS  = 2,
  parameter int TRAIL1_MIN = 4,
  parameter int TRAIL2_MIN = 8,
  parameter int CFG_W      = DEF_W + NUM_AREAS*AREA_W + 1,
  parameter int SEL_W      = $clog2(NUM_AREAS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             acc_req_i,
  input  logic [SEL_W-1:0] area_sel_i,
  input  logic             bus_grant_i,
  output logic             cs_o,
  output logic             ready_o,
  output logic             hold_o,
  output logic             busy_o,
  output logic             bus_req_o,
  output logic             bus_owner_o
);
  localparam int CNT_W    = (DEF_W > AREA_W) ? DEF_W : AREA_W;
  localparam int HOLD_BIT = CFG_W - 1;
  localparam logic [CFG_W-1:0] CFG_RST = {1'b0, {(CFG_W-1){1'b1}}};

  logic [CFG_W-1:0] cfg;
  logic [CNT_W-1:0] sel_ws;
  logic [1:0]       sel_trail;

  sram_ws_cfg #(.CFG_W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  sram_ws_select #(
    .DEF_W(DEF_W), .AREA_W(AREA_W), .NUM_AREAS(NUM_AREAS), .CFG_W(CFG_W),
    .SEL_W(SEL_W), .CNT_W(CNT_W), .TRAIL1_MIN(TRAIL1_MIN), .TRAIL2_MIN(TRAIL2_MIN)
  ) u_sel (
    .cfg_i      (cfg),
    .area_sel_i (area_sel_i),
    .ws_o       (sel_ws),
    .trail_o    (sel_trail)
  );

  sram_ws_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_req_i   (acc_req_i),
    .bus_grant_i (bus_grant_i),
    .ws_i        (sel_ws),
    .trail_i     (sel_trail),
    .cs_o        (cs_o),
    .ready_o     (ready_o),
    .hold_o      (hold_o),
    .busy_o      (busy_o)
  );

  sram_ws_bus u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_req_i  (cfg[HOLD_BIT]),
    .busy_i      (busy_o),
    .bus_grant_i (bus_grant_i),
    .bus_req_o   (bus_req_o),
    .bus_owner_o (bus_owner_o)
  );

  // R8: request covers every active phase
  p_req_in_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o || hold_o) |-> bus_req_o);
  // R5: hold and chip select never overlap
  p_hold_excl_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_o && cs_o));
endmodule

// File: tb/sram_wait_seq_bench.sv
`timescale 1ns/1ps
module sram_wait_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic        acc_req = 1'b0;
  logic [1:0]  area_sel = '0;
  logic        bus_grant = 1'b0;
  logic        cs, ready, hold, busy, bus_req, bus_owner;

  int checks = 0;
  int failures = 0;
  logic [11:0] cfg_m = 12'h7FF;

  always #2.5 clk = ~clk;

  sram_wait_seq u_sram_wait_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .acc_req_i(acc_req), .area_sel_i(area_sel), .bus_grant_i(bus_grant),
    .cs_o(cs), .ready_o(ready), .hold_o(hold), .busy_o(busy),
    .bus_req_o(bus_req), .bus_owner_o(bus_owner)
  );

  function automatic int exp_ws(logic [11:0] c, logic [1:0] a);
    int v;
    case (a)
      2'd1:    v = int'(c[7:5]);
      2'd2:    v = int'(c[10:8]);
      default: v = int'(c[4:0]);
    endcase
    if (v == 0) v = 1;
    return v;
  endfunction

  function automatic int exp_trail(int n);
    if (n >= 8) return 2;
    if (n >= 4) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic write_cfg(input logic [11:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
  endtask

  // inject: 0 none, 1 config write mid-access, 2 extra strobe mid-access
  task automatic run_access(input logic [1:0] area, input int gdel, input int inject,
                            input logic [11:0] new_cfg, input string tag);
    int n_exp, t_exp, cs_n, hold_n, wait_n, rdy_n, rdy_idx, i;
    bit order_bad, req_bad, own_bad;
    logic prev_g;
    n_exp = exp_ws(cfg_m, area);
    t_exp = exp_trail(n_exp);
    cs_n = 0; hold_n = 0; wait_n = 0; rdy_n = 0; rdy_idx = -1; i = 0;
    order_bad = 0; req_bad = 0; own_bad = 0;
    @(negedge clk);
    area_sel = area; acc_req = 1'b1; bus_grant = (gdel == 0);
    prev_g = bus_grant;
    while (1) begin
      @(negedge clk);
      i++;
      if (bus_owner !== prev_g) own_bad = 1;
      if (cs) begin
        cs_n++;
        if (hold_n != 0) order_bad = 1;
      end
      if (ready) begin
        rdy_n++;
        rdy_idx = cs_n;
        if (!cs) order_bad = 1;
      end
      if (hold) begin
        hold_n++;
        if (cs) order_bad = 1;
      end
      if ((cs || hold) && !bus_req) req_bad = 1;
      if (busy && !cs && !hold && cs_n == 0) begin
        wait_n++;
        if (!bus_req) req_bad = 1;
      end
      if (!busy || i > 200) break;
      acc_req = 1'b0; cfg_we = 1'b0;
      if (i == gdel) bus_grant = 1'b1;
      if (i == 2 && inject == 1) begin
        cfg_we = 1'b1; cfg_wdata = new_cfg; cfg_m = new_cfg;
      end
      if (i == 2 && inject == 2) acc_req = 1'b1;
      prev_g = bus_grant;
    end
    acc_req = 1'b0; cfg_we = 1'b0;
    chk(cs_n == n_exp + 1, {tag, " R3 cs length"}, cs_n, n_exp + 1);
    chk(rdy_n == 1 && rdy_idx == cs_n, {tag, " R3 ready in last cs cycle"}, rdy_idx, cs_n);
    chk(hold_n == t_exp, {tag, " R5 trailing length"}, hold_n, t_exp);
    chk(!order_bad, {tag, " R5 phase order"}, int'(order_bad), 0);
    chk(wait_n == gdel, {tag, " R9 grant wait"}, wait_n, gdel);
    chk(!req_bad, {tag, " R8 request while active"}, int'(req_bad), 0);
    chk(!own_bad, {tag, " R10 owner follows grant"}, int'(own_bad), 0);
    chk(bus_req == cfg_m[11], {tag, " R8 idle request"}, int'(bus_req), int'(cfg_m[11]));
    if (inject == 2) begin
      @(negedge clk);
      chk(!busy && !cs, {tag, " R6 strobe while busy ignored"}, int'(busy), 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    chk(!busy && !cs && !ready && !hold && !bus_req, "R1 idle outputs in reset",
        int'({busy, cs, ready, hold, bus_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req, "R1 idle after reset", int'({busy, bus_req}), 0);

    // R1: reset configuration seen through access lengths
    run_access(2'd0, 0, 0, '0, "R1 default 31");
    run_access(2'd1, 0, 0, '0, "R1 area1 7");
    run_access(2'd2, 1, 0, '0, "R1 area2 7");

    // R2: field decode per area code
    write_cfg(12'b0_010_101_00011);
    run_access(2'd0, 0, 0, '0, "R2 code0");
    run_access(2'd1, 0, 0, '0, "R2 code1");
    run_access(2'd2, 0, 0, '0, "R2 code2");
    run_access(2'd3, 0, 0, '0, "R2 code3");

    // R4: zero fields
    write_cfg(12'b0_000_000_00000);
    run_access(2'd0, 0, 0, '0, "R4 zero default");
    run_access(2'd2, 2, 0, '0, "R4 zero area2");

    // R5 boundaries: 3/4, 7/8
    write_cfg(12'b0_100_011_01000);
    run_access(2'd1, 0, 0, '0, "R5 n3");
    run_access(2'd2, 0, 0, '0, "R5 n4");
    run_access(2'd0, 0, 0, '0, "R5 n8");
    write_cfg(12'b0_111_111_00111);
    run_access(2'd0, 0, 0, '0, "R5 n7 default");

    // R7 and R11: write mid-access applies only to the next access
    run_access(2'd1, 0, 1, 12'b0_001_001_00001, "R7 write during access");
    run_access(2'd1, 0, 0, '0, "R11 new value used");

    // R6: strobe during access
    run_access(2'd0, 0, 2, '0, "R6 extra strobe");
    run_access(2'd0, 3, 2, '0, "R6 extra strobe in grant wait");

    // R8: hold-request keeps the request up
    write_cfg(12'b1_010_010_00010);
    @(negedge clk);
    chk(bus_req, "R8 hold bit idle request", int'(bus_req), 1);
    run_access(2'd1, 2, 0, '0, "R8 hold access");
    write_cfg(12'b0_010_010_00010);
    @(negedge clk);
    chk(!bus_req, "R8 request drops when hold clear", int'(bus_req), 0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [11:0] c;
      c = 12'($urandom);
      if ((k % 3) == 0) write_cfg(c);
      run_access(2'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 2)), 12'($urandom), "rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule